// File: doc/BRIEF.md
# BLAKE2b Quarter-Round Mixing Unit

This block applies the 64-bit BLAKE2b mixing function to one group of four state words. It takes the words a, b, c and d together with two message words x and y. It returns the four updated words after a fixed sequence of eight steps, each an add, an XOR or a rotate. A round engine can place four units side by side: one pass handles the four matrix columns and the next pass handles the four diagonals. Message scheduling, round counting, state setup and the final chaining-value fold all stay with the caller.

Operands enter through a valid/ready handshake, and the result leaves through a second valid/ready handshake. The parameter `PIPE_STAGES` chooses the depth:

- With `PIPE_STAGES = 1`, both half-steps are computed in one combinational path and the result is registered once.
- With `PIPE_STAGES = 2`, a register sits between the two half-steps.

The pipeline holds while the result port is stalled, so a result that has not been collected is never overwritten. The pipeline accepts one operand set per cycle when the output is not stalled.

Top module: `b2b_mix_unit`

## Requirements
- R1: The first half uses x: a1 = a + b + x, then d1 = ror64(d XOR a1, 32), then c1 = c + d1, then b1 = ror64(b XOR c1, 24).
- R2: The second half uses y and the first-half words: a2 = a1 + b1 + y, then d2 = ror64(d1 XOR a2, 16), then c2 = c1 + d2, then b2 = ror64(b1 XOR c2, 63). The outputs are a2, b2, c2 and d2.
- R3: Every addition wraps modulo 2^64, and any carry out of bit 63 is dropped.
- R4: Byte 0 is the least significant byte of a word. The rotations behave as follows:
  - ror 32 exchanges the upper and lower 32-bit halves.
  - ror 24 places input byte (i+3) mod 8 at output byte i.
  - ror 16 places input byte (i+2) mod 8 at output byte i.
  - ror 63 equals a left rotation by one bit.
- R5: If out_ready stays high, the result of an operand set accepted at a clock edge (in_valid and in_ready both high) appears with out_valid high exactly PIPE_STAGES edges later.
- R6: While out_valid is high and out_ready is low, out_valid stays high and the four output words do not change.
- R7: in_ready is low exactly while out_valid is high and out_ready is low. Whenever out_valid is low, in_ready is high.
- R8: Asserting rst_n low clears every valid flag at once. During reset out_valid is low and in_ready is high. Reset does not clear the data registers.
- R9: With out_ready high, a new operand set is accepted on every cycle, and the results leave in the order the operands were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set taken at this edge when in_valid is high |
| a_in | input | 64 | State word a |
| b_in | input | 64 | State word b |
| c_in | input | 64 | State word c |
| d_in | input | 64 | State word d |
| x_in | input | 64 | Message word used in the first half |
| y_in | input | 64 | Message word used in the second half |
| out_valid | output | 1 | Result words are valid |
| out_ready | input | 1 | Downstream takes the result at this edge |
| a_out | output | 64 | Updated word a |
| b_out | output | 64 | Updated word b |
| c_out | output | 64 | Updated word c |
| d_out | output | 64 | Updated word d |

## Verification
An operand set accepted at an edge is due on the outputs PIPE_STAGES edges later when out_ready is high. In every cycle the bench samples the ports two nanoseconds before the next rising edge and stamps each accepted operand set with its due cycle. In phases where out_ready is held high, out_valid must equal "a stamped entry has reached its due cycle". In stalled phases the bench checks the order of results, their values, and that held results stay unchanged and in_ready stays low, all against a reference model built from the rotations defined byte by byte.

// File: rtl/b2b_mix_pkg.sv
package b2b_mix_pkg;

  localparam int unsigned WORD_W = 64;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
  } quad_t;

  localparam int unsigned QUAD_W = $bits(quad_t);

  // right rotation by a constant amount, 0 < amt < WORD_W
  function automatic word_t rotr(input word_t v, input int unsigned amt);
    return (v >> amt) | (v << (WORD_W - amt));
  endfunction

endpackage

// File: rtl/b2b_half_mix.sv
module b2b_half_mix
  import b2b_mix_pkg::*;
#(
  parameter int unsigned ROT_D = 32,
  parameter int unsigned ROT_B = 24
) (
  input  quad_t q_i,
  input  word_t m_i,
  output quad_t q_o
);

  word_t sum_a;
  word_t mix_d;
  word_t sum_c;
  word_t mix_b;

  always_comb begin
    sum_a = q_i.a + q_i.b + m_i;
    mix_d = rotr(q_i.d ^ sum_a, ROT_D);
    sum_c = q_i.c + mix_d;
    mix_b = rotr(q_i.b ^ sum_c, ROT_B);
    q_o   = '{a: sum_a, b: mix_b, c: sum_c, d: mix_d};
  end

endmodule

// File: rtl/b2b_stage_reg.sv
module b2b_stage_reg #(
  parameter int unsigned DW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          vld_i,
  input  logic [DW-1:0] dat_i,
  output logic          vld_o,
  output logic [DW-1:0] dat_o
);

  logic          vld_q, vld_d;
  logic [DW-1:0] dat_q;
  logic          dat_en;

  always_comb begin
    vld_d  = adv_i ? vld_i : vld_q;
    dat_en = adv_i & vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (dat_en) dat_q <= dat_i;
  end

  assign vld_o = vld_q;
  assign dat_o = dat_q;

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !adv_i) |=> (vld_o && $stable(dat_o))) else $error("stage lost held word"); // R6

endmodule

// File: rtl/b2b_mix_unit.sv
module b2b_mix_unit
  import b2b_mix_pkg::*;
#(
  parameter int unsigned PIPE_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] a_in,
  input  logic [63:0] b_in,
  input  logic [63:0] c_in,
  input  logic [63:0] d_in,
  input  logic [63:0] x_in,
  input  logic [63:0] y_in,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] a_out,
  output logic [63:0] b_out,
  output logic [63:0] c_out,
  output logic [63:0] d_out
);

  localparam int unsigned MID_W = QUAD_W + WORD_W;

  quad_t in_q;
  quad_t half1_q;
  quad_t half2_q;
  quad_t res_q;
  logic  advance;
  logic  res_vld;
  logic [QUAD_W-1:0] res_bits;

  assign in_q     = '{a: a_in, b: b_in, c: c_in, d: d_in};
  assign advance  = !res_vld || out_ready;
  assign in_ready = advance;

  b2b_half_mix #(.ROT_D(32), .ROT_B(24)) u_half1 (
    .q_i (in_q),
    .m_i (x_in),
    .q_o (half1_q)
  );

  generate
    if (PIPE_STAGES == 2) begin : g_two
      logic             mid_vld;
      logic [MID_W-1:0] mid_bits;
      quad_t            mid_q;
      word_t            mid_y;

      b2b_stage_reg #(.DW(MID_W)) u_mid (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (advance),
        .vld_i (in_valid),
        .dat_i ({half1_q, y_in}),
        .vld_o (mid_vld),
        .dat_o (mid_bits)
      );

      assign mid_q = quad_t'(mid_bits[MID_W-1:WORD_W]);
      assign mid_y = mid_bits[WORD_W-1:0];

      b2b_half_mix #(.ROT_D(16), .ROT_B(63)) u_half2 (
        .q_i (mid_q),
        .m_i (mid_y),
        .q_o (half2_q)
      );

      b2b_stage_reg #(.DW(QUAD_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (advance),
        .vld_i (mid_vld),
        .dat_i (half2_q),
        .vld_o (res_vld),
        .dat_o (res_bits)
      );

      AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2)) else $error("result without entry"); // R5
    end else begin : g_one
      b2b_half_mix #(.ROT_D(16), .ROT_B(63)) u_half2 (
        .q_i (half1_q),
        .m_i (y_in),
        .q_o (half2_q)
      );

      b2b_stage_reg #(.DW(QUAD_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (advance),
        .vld_i (in_valid),
        .dat_i (half2_q),
        .vld_o (res_vld),
        .dat_o (res_bits)
      );

      AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready)) else $error("result without entry"); // R5
    end
  endgenerate

  assign res_q     = quad_t'(res_bits);
  assign out_valid = res_vld;
  assign a_out     = res_q.a;
  assign b_out     = res_q.b;
  assign c_out     = res_q.c;
  assign d_out     = res_q.d;

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready) else $error("input taken during stall"); // R7

  AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready) else $error("input refused while idle"); // R7

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid) else $error("result dropped"); // R6

endmodule

// File: tb/b2b_mix_unit_tb_top.sv
module b2b_mix_unit_tb_top;

  localparam int TB_PIPE = 2;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] a_in, b_in, c_in, d_in, x_in, y_in;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] a_out, b_out, c_out, d_out;

  int checks;
  int failures;
  int cyc;
  bit strict;
  bit stall_mode;
  string cur_tag;

  logic [255:0] exp_q[$];
  int           due_q[$];
  string        tag_q[$];

  logic         prev_ov, prev_ordy;
  logic [255:0] prev_dat;

  b2b_mix_unit #(.PIPE_STAGES(TB_PIPE)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in), .x_in(x_in), .y_in(y_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .a_out(a_out), .b_out(b_out), .c_out(c_out), .d_out(d_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference rotations, written per byte / per half as the requirements state them
  function automatic logic [63:0] r32(input logic [63:0] v);
    return {v[31:0], v[63:32]};
  endfunction
  function automatic logic [63:0] rbytes(input logic [63:0] v, input int k);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*((i + k) % 8) +: 8];
    return r;
  endfunction
  function automatic logic [63:0] r63(input logic [63:0] v);
    return {v[62:0], v[63]};
  endfunction

  function automatic logic [255:0] ref_mix(input logic [63:0] a, b, c, d, x, y);
    logic [63:0] ta, tb, tc, td;
    ta = a; tb = b; tc = c; td = d;
    ta = ta + tb + x;  td = r32(td ^ ta);       tc = tc + td; tb = rbytes(tb ^ tc, 3);
    ta = ta + tb + y;  td = rbytes(td ^ ta, 2); tc = tc + td; tb = r63(tb ^ tc);
    return {ta, tb, tc, td};
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: samples 2 ns before each rising edge
  always begin
    @(negedge clk);
    #8;
    cyc++;
    if (!rst_n) begin
      check(out_valid == 1'b0, "R8 out_valid in reset", {255'd0, out_valid}, 256'd0);
      check(in_ready == 1'b1, "R8 in_ready in reset", {255'd0, in_ready}, 256'd1);
      exp_q.delete(); due_q.delete(); tag_q.delete();
      prev_ov = 1'b0;
      prev_ordy = 1'b1;
    end else begin
      check(in_ready == !(out_valid && !out_ready), "R7 in_ready vs stall",
            {255'd0, in_ready}, {255'd0, !(out_valid && !out_ready)});
      if (prev_ov && !prev_ordy)
        check(out_valid && ({a_out, b_out, c_out, d_out} == prev_dat), "R6 held result",
              {a_out, b_out, c_out, d_out}, prev_dat);
      if (strict)
        check(out_valid == (exp_q.size() > 0 && due_q[0] <= cyc), "R5 latency",
              {255'd0, out_valid}, {255'd0, (exp_q.size() > 0 && due_q[0] <= cyc)});
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected result", {a_out, b_out, c_out, d_out}, 256'd0);
        end else begin
          check({a_out, b_out, c_out, d_out} == exp_q[0], {tag_q[0], " R1 R2 result"},
                {a_out, b_out, c_out, d_out}, exp_q[0]);
          if (out_ready) begin
            void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
          end
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_mix(a_in, b_in, c_in, d_in, x_in, y_in));
        due_q.push_back(cyc + TB_PIPE);
        tag_q.push_back(cur_tag);
      end
      prev_ov = out_valid;
      prev_ordy = out_ready;
      prev_dat = {a_out, b_out, c_out, d_out};
    end
  end

  always begin
    @(negedge clk);
    #1;
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic send(input logic [63:0] a, b, c, d, x, y, input string tag);
    @(negedge clk);
    #2;
    cur_tag = tag;
    in_valid = 1'b1;
    a_in = a; b_in = b; c_in = c; d_in = d; x_in = x; y_in = y;
    forever begin
      #6;
      if (in_ready) break;
      @(negedge clk);
      #2;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    #2;
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() > 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic run_all();
    rst_n = 1'b0; in_valid = 1'b0; strict = 1'b0; stall_mode = 1'b0; cur_tag = "R1";
    a_in = '0; b_in = '0; c_in = '0; d_in = '0; x_in = '0; y_in = '0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    idle(2);
    strict = 1'b1;
    // basic patterns
    send('0, '0, '0, '0, '0, '0, "R1");
    send(64'h0123456789abcdef, 64'hfedcba9876543210, 64'h0f1e2d3c4b5a6978,
         64'h1122334455667788, 64'hdeadbeefcafef00d, 64'h0badc0de12345678, "R2");
    idle(4);
    // wrap-around of every addition
    send('1, '1, '1, '1, '1, '1, "R3");
    send(64'hffffffffffffffff, 64'h1, 64'hfffffffffffffff0, 64'h8000000000000000,
         64'h7fffffffffffffff, 64'hffffffff00000000, "R3");
    idle(4);
    // single-byte and single-bit inputs expose each rotation
    for (int i = 0; i < 8; i++)
      send(64'd0, 64'd0, 64'd0, 64'hff << (8*i), 64'd0, 64'd0, "R4");
    for (int i = 0; i < 8; i++)
      send(64'd0, 64'h1 << (8*i + 3), 64'd0, 64'd0, 64'd0, 64'd0, "R4");
    send(64'd0, 64'd0, 64'd0, 64'h8000000000000001, 64'd0, 64'd0, "R4");
    idle(4);
    // back-to-back stream, one per cycle
    for (int i = 0; i < 24; i++)
      send(rnd64(), rnd64(), rnd64(), rnd64(), rnd64(), rnd64(), "R9");
    idle(4);
    // stalled output
    strict = 1'b0;
    stall_mode = 1'b1;
    for (int i = 0; i < 40; i++)
      send(rnd64(), rnd64(), rnd64(), rnd64(), rnd64(), rnd64(), "R6 R7");
    idle(2);
    drain();
    stall_mode = 1'b0;
    idle(4);
    // reset while results are in flight
    for (int i = 0; i < 3; i++)
      send(rnd64(), rnd64(), rnd64(), rnd64(), rnd64(), rnd64(), "R8");
    @(negedge clk);
    #2;
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    idle(3);
    strict = 1'b1;
    send(rnd64(), rnd64(), rnd64(), rnd64(), rnd64(), rnd64(), "R8");
    idle(6);
    check(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 256'd0);
  endtask

  initial begin
    checks = 0; failures = 0; cyc = 0;
    prev_ov = 1'b0; prev_ordy = 1'b1; prev_dat = '0;
    out_ready = 1'b1;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired act=running exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule